// File: doc/BRIEF.md
# Event Ring with Host Interrupt Handshake

This block gathers event notifications from the internal functions of a multi-port serial adapter and stores them as byte codes in a 32-slot circular ring. The host sees the ring's head entry and both ring indexes, and it is interrupted so that one interrupt can service many queued events. Each per-port event code carries the port number (0 to 3) in its two least significant bits.

Delivery runs through a handshake byte. When the ring holds events and no interrupt is outstanding, the block writes the raise value into the handshake byte and drives the interrupt line. The host acknowledges by writing the acknowledge value. If the host stays silent for a programmable number of cycles (2 ms at the system clock by default), the block pulses the interrupt line low for one cycle, raises it again and increments a 32-bit retry counter. Posts that find no free slot are dropped and set a sticky overflow flag.

Top module: `event_ring_irq`

## Requirements
- R1: Stored codes are 0x20 for initialisation done and 0x21 for initialisation failure. Per port p they are 0x18|p for a control-line change, 0x24|p for an abort sent and 0x28|p for a transmit underflow. The byte at the read index appears on `headEntry`.
- R2: All posts raised in one cycle are stored in that edge in consecutive slots from the write index. The order is init done, init failure, then for each port from 0 to 3: control change, abort, underflow. The write index then moves by the number stored, modulo 32.
- R3: The ring holds at most 31 entries. Free space is judged on the occupancy at the start of the cycle, so a read advance in the same cycle frees nothing. Posts beyond the free space are dropped in priority order, and `overflowFlag` goes high and stays high until reset.
- R4: A pulse on `hostRdAdvance` while the ring is non-empty moves the read index by one, modulo 32. On an empty ring it has no effect.
- R5: After reset both indexes are 0, the handshake byte is 0x00, the interrupt is low, the retry counter is 0 and the overflow flag is low.
- R6: At a clock edge where the ring is non-empty and no interrupt is outstanding, the handshake byte becomes 0x01 and `hostIrq` goes high. A post therefore raises `hostIrq` two edges after it is sampled.
- R7: A host write of 0xEE sets the handshake byte to 0xEE, clears the outstanding interrupt and drops `hostIrq` after that edge. A write of any other value is ignored.
- R8: If the interrupt stays outstanding for RETRY_CYCLES edges without an acknowledge, `retryCount` increments by one and `hostIrq` is low for exactly one cycle. The handshake byte stays 0x01. An acknowledge in the expiry cycle wins, and the counter is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | Post: initialisation completed |
| initFail | input | 1 | Post: initialisation failed |
| ctlChange | input | 4 | Post per port: control line changed |
| abortSent | input | 4 | Post per port: abort transmitted |
| txUnderflow | input | 4 | Post per port: transmit underflow |
| hostRdAdvance | input | 1 | Host consumed the head entry |
| hostHsWrite | input | 1 | Host writes the handshake byte |
| hostHsData | input | 8 | Value of the host handshake write |
| hostIrq | output | 1 | Interrupt to host |
| hsByte | output | 8 | Current handshake byte |
| rdIndex | output | 5 | Ring read index |
| wrIndex | output | 5 | Ring write index |
| headEntry | output | 8 | Code stored at the read index |
| retryCount | output | 32 | Count of unacknowledged-interrupt retries |
| overflowFlag | output | 1 | Sticky: a post was dropped |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the host acknowledge and the retry timer expiry. The bench tracks its own model of the retry timer and drives the 0xEE write exactly in the expiry cycle; it then expects an unchanged retry counter, a handshake byte of 0xEE and no interrupt gap. The second pair is a read advance and a post against a full ring. Here the bench expects the post to be dropped with the overflow flag set while the read index still moves, and it compares every output with its behavioural model on each clock.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int PORTS     = 4;
  localparam int SRC_COUNT = 2 + 3 * PORTS;
  localparam int CNT_W     = $clog2(SRC_COUNT + 1);

  localparam logic [7:0] CODE_INIT_OK   = 8'h20;
  localparam logic [7:0] CODE_INIT_BAD  = 8'h21;
  localparam logic [7:0] CODE_CTL_BASE  = 8'h18;
  localparam logic [7:0] CODE_ABORT_BASE = 8'h24;
  localparam logic [7:0] CODE_UNDF_BASE = 8'h28;

  localparam logic [7:0] HS_RAISE = 8'h01;
  localparam logic [7:0] HS_ACK   = 8'hEE;
  localparam logic [7:0] HS_RESET = 8'h00;

  typedef struct packed {
    logic [CNT_W-1:0]              wrNum;
    logic [SRC_COUNT-1:0][7:0]     slotCode;
    logic                          popEn;
    logic                          retryInc;
    logic                          overflowSet;
  } evqStrobes_t;
endpackage

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int RETRY_CYCLES = 400000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       initDone,
  input  logic                       initFail,
  input  logic [PORTS-1:0]           ctlChange,
  input  logic [PORTS-1:0]           abortSent,
  input  logic [PORTS-1:0]           txUnderflow,
  input  logic                       hostRdAdvance,
  input  logic                       hostHsWrite,
  input  logic [7:0]                 hostHsData,
  input  logic [$clog2(DEPTH):0]     occupancy,
  output evqStrobes_t                strobes,
  output logic [7:0]                 hsByte,
  output logic                       hostIrq
);
  localparam int TMR_W = $clog2(RETRY_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RETRY_CYCLES - 1);

  // Ordered request vector and matching codes; index order is priority.
  logic [SRC_COUNT-1:0]      reqVec;
  logic [SRC_COUNT-1:0][7:0] srcCode;

  assign reqVec[0]  = initDone;
  assign srcCode[0] = CODE_INIT_OK;
  assign reqVec[1]  = initFail;
  assign srcCode[1] = CODE_INIT_BAD;

  for (genvar p = 0; p < PORTS; p++) begin : g_port_src
    assign reqVec[2 + 3*p]  = ctlChange[p];
    assign srcCode[2 + 3*p] = CODE_CTL_BASE | 8'(p);
    assign reqVec[3 + 3*p]  = abortSent[p];
    assign srcCode[3 + 3*p] = CODE_ABORT_BASE | 8'(p);
    assign reqVec[4 + 3*p]  = txUnderflow[p];
    assign srcCode[4 + 3*p] = CODE_UNDF_BASE | 8'(p);
  end

  // Pack accepted requests into consecutive slots, limited by free space.
  int unsigned      freeSlots;
  logic [CNT_W-1:0] acc;
  logic             dropAny;
  logic [SRC_COUNT-1:0][7:0] packedCodes;

  always_comb begin
    freeSlots   = 32'(DEPTH - 1) - 32'(occupancy);
    acc         = '0;
    dropAny     = 1'b0;
    packedCodes = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (reqVec[i]) begin
        if (32'(acc) < freeSlots) begin
          packedCodes[acc] = srcCode[i];
          acc = acc + CNT_W'(1);
        end else begin
          dropAny = 1'b1;
        end
      end
    end
  end

  // Handshake state.
  logic             pending;
  logic             gap;
  logic [TMR_W-1:0] timer;
  logic [7:0]       hsReg;
  logic             ackNow;
  logic             expire;

  assign ackNow = hostHsWrite && (hostHsData == HS_ACK);
  assign expire = pending && !ackNow && (timer == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      gap     <= 1'b0;
      timer   <= '0;
      hsReg   <= HS_RESET;
    end else begin
      gap <= 1'b0;
      if (ackNow) begin
        hsReg   <= HS_ACK;
        pending <= 1'b0;
        timer   <= '0;
      end else if (pending) begin
        if (expire) begin
          timer <= '0;
          gap   <= 1'b1;
        end else begin
          timer <= timer + TMR_W'(1);
        end
      end else if (occupancy != '0) begin
        pending <= 1'b1;
        hsReg   <= HS_RAISE;
        timer   <= '0;
      end
    end
  end

  always_comb begin
    strobes.wrNum       = acc;
    strobes.slotCode    = packedCodes;
    strobes.popEn       = hostRdAdvance && (occupancy != '0);
    strobes.retryInc    = expire;
    strobes.overflowSet = dropAny;
  end

  assign hsByte  = hsReg;
  assign hostIrq = pending && !gap;

  // R6: the line is only high while the raise value is posted.
  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> (hsByte == HS_RAISE));

  // R7: acknowledge drops the interrupt and records the ack byte.
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackNow |=> (!hostIrq && hsByte == HS_ACK));

  // R7: a foreign value does not disturb an outstanding raise.
  p_foreign_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostHsWrite && hostHsData != HS_ACK && pending) |=> (hsByte == HS_RAISE));

  // R8: retry produces a one-cycle low gap.
  p_retry_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retryInc |=> (!hostIrq && hsByte == HS_RAISE));

  // R4: nothing is consumed from an empty ring.
  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == '0) |-> !strobes.popEn);
endmodule

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  evqStrobes_t              strobes,
  output logic [$clog2(DEPTH)-1:0] rdIndex,
  output logic [$clog2(DEPTH)-1:0] wrIndex,
  output logic [$clog2(DEPTH):0]   occupancy,
  output logic [7:0]               headEntry,
  output logic [31:0]              retryCount,
  output logic                     overflowFlag
);
  localparam int AW    = $clog2(DEPTH);
  localparam int OCC_W = AW + 1;

  logic [7:0]       ringMem [DEPTH];
  logic [AW-1:0]    rdIdx;
  logic [AW-1:0]    wrIdx;
  logic [OCC_W-1:0] occ;

  always_ff @(posedge clk) begin
    for (int k = 0; k < SRC_COUNT; k++) begin
      if (k < int'(strobes.wrNum)) begin
        ringMem[wrIdx + AW'(k)] <= strobes.slotCode[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx        <= '0;
      wrIdx        <= '0;
      occ          <= '0;
      retryCount   <= '0;
      overflowFlag <= 1'b0;
    end else begin
      wrIdx <= wrIdx + AW'(strobes.wrNum);
      if (strobes.popEn) rdIdx <= rdIdx + AW'(1);
      occ <= occ + OCC_W'(strobes.wrNum) - OCC_W'(strobes.popEn);
      if (strobes.retryInc) retryCount <= retryCount + 32'd1;
      if (strobes.overflowSet) overflowFlag <= 1'b1;
    end
  end

  assign rdIndex   = rdIdx;
  assign wrIndex   = wrIdx;
  assign occupancy = occ;
  assign headEntry = ringMem[rdIdx];

  // R3: occupancy never reaches the full ring size.
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH - 1));

  // R3: the overflow flag is sticky.
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R8: each retry strobe adds exactly one.
  p_retry_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retryInc |=> (retryCount == $past(retryCount) + 32'd1));

  // R2: write index moves by the number of codes accepted.
  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrNum == '0) |=> $stable(wrIdx));
endmodule

// File: rtl/event_ring_irq.sv
module event_ring_irq
  import evq_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int RETRY_CYCLES = 400000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     initDone,
  input  logic                     initFail,
  input  logic [3:0]               ctlChange,
  input  logic [3:0]               abortSent,
  input  logic [3:0]               txUnderflow,
  input  logic                     hostRdAdvance,
  input  logic                     hostHsWrite,
  input  logic [7:0]               hostHsData,
  output logic                     hostIrq,
  output logic [7:0]               hsByte,
  output logic [$clog2(DEPTH)-1:0] rdIndex,
  output logic [$clog2(DEPTH)-1:0] wrIndex,
  output logic [7:0]               headEntry,
  output logic [31:0]              retryCount,
  output logic                     overflowFlag
);
  evqStrobes_t            strobes;
  logic [$clog2(DEPTH):0] occupancy;

  evq_ctrl #(.DEPTH(DEPTH), .RETRY_CYCLES(RETRY_CYCLES)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .initDone     (initDone),
    .initFail     (initFail),
    .ctlChange    (ctlChange),
    .abortSent    (abortSent),
    .txUnderflow  (txUnderflow),
    .hostRdAdvance(hostRdAdvance),
    .hostHsWrite  (hostHsWrite),
    .hostHsData   (hostHsData),
    .occupancy    (occupancy),
    .strobes      (strobes),
    .hsByte       (hsByte),
    .hostIrq      (hostIrq)
  );

  evq_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rdIndex     (rdIndex),
    .wrIndex     (wrIndex),
    .occupancy   (occupancy),
    .headEntry   (headEntry),
    .retryCount  (retryCount),
    .overflowFlag(overflowFlag)
  );
endmodule

// File: tb/test_event_ring_irq.sv
`timescale 1ns/1ps
module test_event_ring_irq;
  localparam int RETRY = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initDone = 0, initFail = 0;
  logic [3:0] ctlChange = 0, abortSent = 0, txUnderflow = 0;
  logic hostRdAdvance = 0, hostHsWrite = 0;
  logic [7:0] hostHsData = 0;
  logic hostIrq;
  logic [7:0] hsByte, headEntry;
  logic [4:0] rdIndex, wrIndex;
  logic [31:0] retryCount;
  logic overflowFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  event_ring_irq #(.DEPTH(32), .RETRY_CYCLES(RETRY)) i_event_ring_irq (
    .clk(clk), .rstN(rstN), .initDone(initDone), .initFail(initFail),
    .ctlChange(ctlChange), .abortSent(abortSent), .txUnderflow(txUnderflow),
    .hostRdAdvance(hostRdAdvance), .hostHsWrite(hostHsWrite), .hostHsData(hostHsData),
    .hostIrq(hostIrq), .hsByte(hsByte), .rdIndex(rdIndex), .wrIndex(wrIndex),
    .headEntry(headEntry), .retryCount(retryCount), .overflowFlag(overflowFlag));

  // Behavioural reference model.
  int mq[$];
  int mRd, mWr, mTimer, mHs;
  bit mPend, mGap, mOvf;
  int unsigned mRetry;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int cnt, freeN, n;
    int req[$];
    bit ack;
    if (!rstN) begin
      mq.delete(); mRd = 0; mWr = 0; mTimer = 0; mHs = 0;
      mPend = 0; mGap = 0; mOvf = 0; mRetry = 0;
    end else begin
      cnt = mq.size();
      freeN = 31 - cnt;
      req.delete();
      if (initDone) req.push_back(8'h20);
      if (initFail) req.push_back(8'h21);
      for (int p = 0; p < 4; p++) begin
        if (ctlChange[p])   req.push_back(8'h18 + p);
        if (abortSent[p])   req.push_back(8'h24 + p);
        if (txUnderflow[p]) req.push_back(8'h28 + p);
      end
      ack = hostHsWrite && hostHsData == 8'hEE;
      mGap = 0;
      if (ack) begin
        mHs = 8'hEE; mPend = 0; mTimer = 0;
      end else if (mPend) begin
        if (mTimer == RETRY - 1) begin mTimer = 0; mRetry++; mGap = 1; end
        else mTimer++;
      end else if (cnt > 0) begin
        mPend = 1; mHs = 8'h01; mTimer = 0;
      end
      if (hostRdAdvance && cnt > 0) begin
        void'(mq.pop_front());
        mRd = (mRd + 1) % 32;
      end
      n = 0;
      foreach (req[i]) begin
        if (n < freeN) begin mq.push_back(req[i]); n++; end
        else mOvf = 1;
      end
      mWr = (mWr + n) % 32;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R6 hostIrq", hostIrq, mPend && !mGap);
      chk("R7 hsByte", hsByte, mHs);
      chk("R8 retryCount", retryCount, mRetry);
      chk("R3 overflowFlag", overflowFlag, mOvf);
      chk("R2 wrIndex", wrIndex, mWr);
      chk("R4 rdIndex", rdIndex, mRd);
      if (mq.size() > 0) chk("R1 headEntry", headEntry, mq[0]);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearIn();
    initDone = 0; initFail = 0; ctlChange = 0; abortSent = 0; txUnderflow = 0;
    hostRdAdvance = 0; hostHsWrite = 0; hostHsData = 0;
  endtask

  task automatic hostWrite(logic [7:0] v);
    @(negedge clk); hostHsWrite = 1; hostHsData = v;
    @(negedge clk); hostHsWrite = 0;
  endtask

  task automatic drain();
    while (mq.size() > 0) begin
      @(negedge clk); hostRdAdvance = 1;
      @(negedge clk); hostRdAdvance = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    clearIn();
    idle(3);
    // R5: reset state
    chk("R5 rdIndex", rdIndex, 0);
    chk("R5 wrIndex", wrIndex, 0);
    chk("R5 hsByte", hsByte, 0);
    chk("R5 hostIrq", hostIrq, 0);
    chk("R5 retryCount", retryCount, 0);
    chk("R5 overflowFlag", overflowFlag, 0);
    rstN = 1;
    idle(2);

    // R6: single post raises the interrupt two edges later
    initDone = 1;
    @(negedge clk); initDone = 0;
    chk("R1 first code", headEntry, 8'h20);
    chk("R6 irq low after 1 edge", hostIrq, 0);
    @(negedge clk);
    chk("R6 irq high after 2 edges", hostIrq, 1);
    chk("R6 hs raise", hsByte, 8'h01);
    // R7: foreign value ignored
    hostWrite(8'h5A);
    chk("R7 foreign ignored", hsByte, 8'h01);
    chk("R7 irq kept", hostIrq, 1);
    // R7: acknowledge
    @(negedge clk); hostHsWrite = 1; hostHsData = 8'hEE; hostRdAdvance = 1;
    @(negedge clk); clearIn();
    chk("R7 hs ack", hsByte, 8'hEE);
    chk("R7 irq dropped", hostIrq, 0);
    chk("R4 read advanced", rdIndex, 1);
    idle(2);

    // R2: all sources at once
    initDone = 1; initFail = 1; ctlChange = 4'hF; abortSent = 4'hF; txUnderflow = 4'hF;
    @(negedge clk); clearIn();
    chk("R2 wrIndex after 14", wrIndex, 15);
    chk("R1 head init done", headEntry, 8'h20);
    drain();
    // R1/R2: sparse mix on ports 1 and 3
    ctlChange = 4'b1000; txUnderflow = 4'b0010; abortSent = 4'b0010;
    @(negedge clk); clearIn();
    chk("R2 first of mix", headEntry, 8'h25);
    drain();
    hostWrite(8'hEE);

    // R3: overflow
    for (int k = 0; k < 3; k++) begin
      initDone = 1; initFail = 1; ctlChange = 4'hF; abortSent = 4'hF; txUnderflow = 4'hF;
      @(negedge clk); clearIn();
    end
    chk("R3 overflow set", overflowFlag, 1);
    chk("R3 ring holds 31", mq.size(), 31);
    // R3: post and pop in the same cycle on a full ring
    r0 = wrIndex;
    initDone = 1; hostRdAdvance = 1;
    @(negedge clk); clearIn();
    chk("R3 post dropped when full", wrIndex, r0);
    drain();
    // R4: advance on empty
    r0 = rdIndex;
    hostRdAdvance = 1;
    @(negedge clk); clearIn();
    chk("R4 empty advance ignored", rdIndex, r0);
    hostWrite(8'hEE);
    idle(2);

    // R8: plain timeout
    abortSent = 4'b0100;
    @(negedge clk); clearIn();
    r0 = retryCount;
    while (!(mPend && mGap)) @(negedge clk);
    chk("R8 retry incremented", retryCount, r0 + 1);
    chk("R8 gap low", hostIrq, 0);
    @(negedge clk);
    chk("R8 irq back", hostIrq, 1);
    chk("R8 hs stays raise", hsByte, 8'h01);
    // R8: acknowledge in the expiry cycle wins
    r0 = retryCount;
    while (!(mPend && mTimer == RETRY - 1)) @(negedge clk);
    hostHsWrite = 1; hostHsData = 8'hEE;
    @(negedge clk); clearIn();
    chk("R8 ack beats expiry", retryCount, r0);
    chk("R8 hs ack at expiry", hsByte, 8'hEE);
    chk("R8 no gap, irq low", hostIrq, 0);
    @(negedge clk);
    chk("R6 re-raise after ack", hostIrq, 1);
    drain();
    hostWrite(8'hEE);
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule